// File: doc/BRIEF.md
# Width-Aware Variant Shift and Rotate Unit

This block is the shift datapath of a processor execution stage. Each clock it takes a 32-bit register operand, an active width of 8, 16 or 32 bits, a direction, a variant bit, a carry-in and a shift amount. The amount comes either from an immediate field or from the low bits of a second register. One cycle later it returns the shifted value, the new carry, and negative and zero flags. The flags are judged at the active width only. For 8-bit and 16-bit work, only the low lane of the operand is rewritten. The register bits above the lane come back exactly as they went in, so the result can be written straight back to the register file.

The direction, rotate and variant inputs select one of eight operation kinds, each named in the package enum:
- `K_SHR_ZERO`: right shift with zero fill.
- `K_SHR_SIGN`: right shift that copies the top bit of the lane.
- `K_SHL_ZERO`: left shift with zero fill.
- `K_SHL_REP`: left shift that copies bit 0.
- `K_ROR_CARRY` and `K_ROL_CARRY`: rotates through the carry flag.
- `K_ROR_WRAP` and `K_ROL_WRAP`: rotates that wrap inside the lane.

Every kind accepts any amount from 0 to 63 in one step.

The unit has no handshake. The inputs are captured on every rising edge, and the outputs describe the inputs of the previous edge.

Top module: `vshift_unit`

## Requirements
- R1: All outputs are registered: the result and flags for the inputs present at a rising edge appear after that edge and hold until the next one; an active-low asynchronous reset clears result_o, carry_o, neg_o and zero_o to 0.
- R2: With rotate_i=0, left_i=0, alt_i=0 the lane shifts right with zero fill; carry_o is the last bit shifted out; any amount at or above the lane width gives a zero lane, and an amount above the width gives carry_o=0.
- R3: With rotate_i=0, left_i=0, alt_i=1 the shift right refills with bit (w-1) of the lane; amounts above the width give a lane and carry_o all equal to that bit.
- R4: With rotate_i=0, left_i=1, alt_i=0 the lane shifts left with zero fill; carry_o is the last bit shifted out of bit (w-1).
- R5: With rotate_i=0, left_i=1, alt_i=1 the shift left refills bit 0 with the original bit 0; amounts above the width give a lane and carry_o all equal to that bit.
- R6: With rotate_i=1, alt_i=0 the lane and carry form a (w+1)-bit ring: a right rotate moves carry into bit (w-1) and bit 0 into carry, a left rotate moves carry into bit 0 and bit (w-1) into carry; the amount acts modulo w+1.
- R7: With rotate_i=1, alt_i=1 the rotate wraps inside the lane (amount modulo w) and carry_o equals the last bit moved across the lane boundary: bit (w-1) of the result for right, bit 0 for left.
- R8: An amount of zero returns the operand unchanged and carry_o equal to carry_i, for every kind.
- R9: width_i selects the lane: 2'b00 is 8 bits, 2'b01 is 16 bits, 2'b10 and 2'b11 are 32 bits; result bits above the lane equal the operand's.
- R10: neg_o equals bit (w-1) of the result, and zero_o is 1 exactly when bits (w-1:0) of the result are all zero.
- R11: With amt_from_reg_i=1 the amount is amt_reg_i[5:0] and the upper register bits are ignored; with it 0 the amount is amt_imm_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| operand_i | input | 32 | Value to shift or rotate |
| width_i | input | 2 | Lane width code (00=8, 01=16, 10/11=32) |
| left_i | input | 1 | 1 = toward bit 31, 0 = toward bit 0 |
| alt_i | input | 1 | Variant: sign/low-bit fill for shifts, in-lane wrap for rotates |
| rotate_i | input | 1 | 1 = rotate, 0 = shift |
| carry_i | input | 1 | Incoming carry flag |
| amt_from_reg_i | input | 1 | 1 = amount from amt_reg_i, 0 = from amt_imm_i |
| amt_imm_i | input | 6 | Immediate shift amount |
| amt_reg_i | input | 32 | Register supplying the shift amount |
| result_o | output | 32 | Shifted value, upper bits preserved for narrow lanes |
| carry_o | output | 1 | New carry flag |
| neg_o | output | 1 | Top bit of the active lane |
| zero_o | output | 1 | Active lane is zero |

## Verification
The hardest corner to reach is the through-carry ring when the amount is at or beyond a whole turn of w+1 bits. In this corner an 8-bit lane holds non-zero upper register bits, and the returned carry comes from a bit that has already circled once. The same holds for the fill kinds when the amount overshoots the lane by more than one position. The stimulus names these amounts directly (9, 18, 35, 63 against 8- and 32-bit lanes). It then sweeps every kind, width code and source of the amount with random operands and amounts spanning the full 0 to 63 range. A bit-at-a-time reference checks every cycle.

// File: rtl/sft_pkg.sv
package sft_pkg;

    localparam int SFT_DATA_W = 32;
    localparam int SFT_AMT_W  = 6;
    localparam int SFT_MIN_W  = 8;
    localparam int SFT_NLANE  = 3;

    // encoding is {rotate, left, alt}
    typedef enum logic [2:0] {
        K_SHR_ZERO  = 3'b000,
        K_SHR_SIGN  = 3'b001,
        K_SHL_ZERO  = 3'b010,
        K_SHL_REP   = 3'b011,
        K_ROR_CARRY = 3'b100,
        K_ROR_WRAP  = 3'b101,
        K_ROL_CARRY = 3'b110,
        K_ROL_WRAP  = 3'b111
    } sft_kind_e;

endpackage

// File: rtl/sft_decode.sv
module sft_decode
    import sft_pkg::*;
#(
    parameter int DATA_W = SFT_DATA_W,
    parameter int AMT_W  = SFT_AMT_W
) (
    input  logic              left_i,
    input  logic              alt_i,
    input  logic              rotate_i,
    input  logic              amt_from_reg_i,
    input  logic [AMT_W-1:0]  amt_imm_i,
    input  logic [DATA_W-1:0] amt_reg_i,
    output sft_kind_e         kind_o,
    output logic [AMT_W-1:0]  amt_o
);

    logic unused_amt_hi;
    assign unused_amt_hi = ^amt_reg_i[DATA_W-1:AMT_W];

    always_comb begin
        unique case ({rotate_i, left_i, alt_i})
            3'b000:  kind_o = K_SHR_ZERO;
            3'b001:  kind_o = K_SHR_SIGN;
            3'b010:  kind_o = K_SHL_ZERO;
            3'b011:  kind_o = K_SHL_REP;
            3'b100:  kind_o = K_ROR_CARRY;
            3'b101:  kind_o = K_ROR_WRAP;
            3'b110:  kind_o = K_ROL_CARRY;
            default: kind_o = K_ROL_WRAP;
        endcase
    end

    assign amt_o = amt_from_reg_i ? amt_reg_i[AMT_W-1:0] : amt_imm_i;

endmodule

// File: rtl/sft_lane.sv
module sft_lane
    import sft_pkg::*;
#(
    parameter int W     = 8,
    parameter int AMT_W = SFT_AMT_W
) (
    input  logic [W-1:0]     x_i,
    input  logic             c_i,
    input  logic [AMT_W-1:0] amt_i,
    input  sft_kind_e        kind_i,
    output logic [W-1:0]     res_o,
    output logic             c_o
);

    localparam int SW = $clog2(W) + 1;

    logic [31:0]    amt_u;
    logic [SW-1:0]  sat_amt;
    logic [7:0]     k_wrap;
    logic [7:0]     k_ring;
    logic           beyond;
    logic           fill_r;
    logic           fill_l;
    logic [2*W-1:0] ext_r, ext_l, sh_r, sh_l, last_r, last_l;
    logic [2*W-1:0] dbl_x, rot_r, rot_l;
    logic [2*W+1:0] dbl_ring, ring_r, ring_l;

    assign amt_u   = 32'(amt_i);
    assign beyond  = amt_u > 32'(W);
    assign sat_amt = (amt_u >= 32'(W)) ? SW'(W) : SW'(amt_u);
    assign k_wrap  = 8'(amt_u % 32'(W));
    assign k_ring  = 8'(amt_u % 32'(W + 1));

    assign fill_r = (kind_i == K_SHR_SIGN) ? x_i[W-1] : 1'b0;
    assign fill_l = (kind_i == K_SHL_REP)  ? x_i[0]   : 1'b0;

    // plain shifts: operand beside a block of fill bits
    assign ext_r  = {{W{fill_r}}, x_i};
    assign ext_l  = {x_i, {W{fill_l}}};
    assign sh_r   = ext_r >> sat_amt;
    assign sh_l   = ext_l << sat_amt;
    assign last_r = ext_r >> (sat_amt - SW'(1));
    assign last_l = ext_l << (sat_amt - SW'(1));

    // rotates: doubled operand or doubled carry ring
    assign dbl_x    = {x_i, x_i};
    assign rot_r    = dbl_x >> k_wrap;
    assign rot_l    = dbl_x << k_wrap;
    assign dbl_ring = {c_i, x_i, c_i, x_i};
    assign ring_r   = dbl_ring >> k_ring;
    assign ring_l   = dbl_ring << k_ring;

    always_comb begin
        res_o = x_i;
        c_o   = c_i;
        unique case (kind_i)
            K_SHR_ZERO, K_SHR_SIGN: begin
                res_o = sh_r[W-1:0];
                c_o   = beyond ? fill_r : last_r[0];
            end
            K_SHL_ZERO, K_SHL_REP: begin
                res_o = sh_l[2*W-1:W];
                c_o   = beyond ? fill_l : last_l[2*W-1];
            end
            K_ROR_WRAP: begin
                res_o = rot_r[W-1:0];
                c_o   = rot_r[W-1];
            end
            K_ROL_WRAP: begin
                res_o = rot_l[2*W-1:W];
                c_o   = rot_l[W];
            end
            K_ROR_CARRY: begin
                res_o = ring_r[W-1:0];
                c_o   = ring_r[W];
            end
            K_ROL_CARRY: begin
                res_o = ring_l[2*W:W+1];
                c_o   = ring_l[2*W+1];
            end
        endcase
        if (amt_u == 32'd0) begin
            res_o = x_i;
            c_o   = c_i;
        end
    end

endmodule

// File: rtl/sft_flags.sv
module sft_flags
    import sft_pkg::*;
#(
    parameter int DATA_W = SFT_DATA_W
) (
    input  logic [DATA_W-1:0] res_i,
    input  logic [1:0]        lane_sel_i,
    output logic              neg_o,
    output logic              zero_o
);

    always_comb begin
        unique case (lane_sel_i)
            2'd0: begin
                neg_o  = res_i[7];
                zero_o = (res_i[7:0] == 8'd0);
            end
            2'd1: begin
                neg_o  = res_i[15];
                zero_o = (res_i[15:0] == 16'd0);
            end
            default: begin
                neg_o  = res_i[DATA_W-1];
                zero_o = (res_i == '0);
            end
        endcase
    end

endmodule

// File: rtl/vshift_unit.sv
module vshift_unit
    import sft_pkg::*;
#(
    parameter int AMT_W = SFT_AMT_W
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [SFT_DATA_W-1:0] operand_i,
    input  logic [1:0]            width_i,
    input  logic                  left_i,
    input  logic                  alt_i,
    input  logic                  rotate_i,
    input  logic                  carry_i,
    input  logic                  amt_from_reg_i,
    input  logic [AMT_W-1:0]      amt_imm_i,
    input  logic [SFT_DATA_W-1:0] amt_reg_i,
    output logic [SFT_DATA_W-1:0] result_o,
    output logic                  carry_o,
    output logic                  neg_o,
    output logic                  zero_o
);

    localparam int DATA_W = SFT_DATA_W;
    localparam int NLANE  = SFT_NLANE;

    sft_kind_e                         kind;
    logic [AMT_W-1:0]                  amt;
    logic [NLANE-1:0][DATA_W-1:0]      lane_res;
    logic [NLANE-1:0][DATA_W-1:0]      lane_mask;
    logic [NLANE-1:0]                  lane_c;
    logic [1:0]                        lane_sel;
    logic [DATA_W-1:0]                 merged;
    logic                              merged_c;
    logic                              n_d, z_d;

    sft_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_decode (
        .left_i         (left_i),
        .alt_i          (alt_i),
        .rotate_i       (rotate_i),
        .amt_from_reg_i (amt_from_reg_i),
        .amt_imm_i      (amt_imm_i),
        .amt_reg_i      (amt_reg_i),
        .kind_o         (kind),
        .amt_o          (amt)
    );

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int LW = SFT_MIN_W << g;
        logic [LW-1:0] res_w;

        sft_lane #(.W(LW), .AMT_W(AMT_W)) u_lane (
            .x_i    (operand_i[LW-1:0]),
            .c_i    (carry_i),
            .amt_i  (amt),
            .kind_i (kind),
            .res_o  (res_w),
            .c_o    (lane_c[g])
        );

        assign lane_res[g]  = DATA_W'(res_w);
        assign lane_mask[g] = DATA_W'((64'd1 << LW) - 64'd1);
    end

    assign lane_sel = (width_i == 2'b11) ? 2'd2 : width_i;
    assign merged   = (operand_i & ~lane_mask[lane_sel]) | lane_res[lane_sel];
    assign merged_c = lane_c[lane_sel];

    sft_flags #(.DATA_W(DATA_W)) u_flags (
        .res_i      (merged),
        .lane_sel_i (lane_sel),
        .neg_o      (n_d),
        .zero_o     (z_d)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            result_o <= '0;
            carry_o  <= 1'b0;
            neg_o    <= 1'b0;
            zero_o   <= 1'b0;
        end else begin
            result_o <= merged;
            carry_o  <= merged_c;
            neg_o    <= n_d;
            zero_o   <= z_d;
        end
    end

endmodule

// File: rtl/vshift_unit_chk.sv
module vshift_unit_chk
    import sft_pkg::*;
#(
    parameter int AMT_W = SFT_AMT_W
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic [SFT_DATA_W-1:0] operand_i,
    input logic [1:0]            width_i,
    input logic                  left_i,
    input logic                  alt_i,
    input logic                  rotate_i,
    input logic                  carry_i,
    input logic                  amt_from_reg_i,
    input logic [AMT_W-1:0]      amt_imm_i,
    input logic [SFT_DATA_W-1:0] amt_reg_i,
    input logic [SFT_DATA_W-1:0] result_o,
    input logic                  carry_o,
    input logic                  neg_o,
    input logic                  zero_o
);

    logic             primed;
    logic [AMT_W-1:0] amt_now;

    assign amt_now = amt_from_reg_i ? amt_reg_i[AMT_W-1:0] : amt_imm_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) primed <= 1'b0;
        else         primed <= 1'b1;
    end

    function automatic logic top_bit(input logic [31:0] v, input logic [1:0] wc);
        case (wc)
            2'b00:   return v[7];
            2'b01:   return v[15];
            default: return v[31];
        endcase
    endfunction

    function automatic logic lane_zero(input logic [31:0] v, input logic [1:0] wc);
        case (wc)
            2'b00:   return v[7:0] == 8'd0;
            2'b01:   return v[15:0] == 16'd0;
            default: return v == 32'd0;
        endcase
    endfunction

    // R9: narrow lane leaves the upper register bits alone
    assert_upper_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (primed && $past(width_i) == 2'b00) |-> result_o[31:8] == $past(operand_i[31:8]));

    // R8: zero amount is a no-op on value and carry
    assert_zero_amount_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (primed && $past(amt_now) == '0) |-> (result_o == $past(operand_i) && carry_o == $past(carry_i)));

    // R10: negative flag tracks the lane's top bit
    assert_neg_top_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        primed |-> neg_o == top_bit(result_o, $past(width_i)));

    // R10: zero flag tracks the active lane
    assert_zero_lane_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        primed |-> zero_o == lane_zero(result_o, $past(width_i)));

    // R7: right in-lane rotate leaves the moved bit in carry
    assert_wrap_carry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (primed && $past(rotate_i && alt_i && !left_i) && $past(amt_now) != '0)
        |-> carry_o == top_bit(result_o, $past(width_i)));

    // R2: logical right shift by at least the lane width empties the 8-bit lane
    assert_flush_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (primed && $past(!rotate_i && !left_i && !alt_i && width_i == 2'b00 && amt_now >= 8))
        |-> (result_o[7:0] == 8'd0 && zero_o));

endmodule

bind vshift_unit vshift_unit_chk u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .operand_i      (operand_i),
    .width_i        (width_i),
    .left_i         (left_i),
    .alt_i          (alt_i),
    .rotate_i       (rotate_i),
    .carry_i        (carry_i),
    .amt_from_reg_i (amt_from_reg_i),
    .amt_imm_i      (amt_imm_i),
    .amt_reg_i      (amt_reg_i),
    .result_o       (result_o),
    .carry_o        (carry_o),
    .neg_o          (neg_o),
    .zero_o         (zero_o)
);

// File: tb/vshift_unit_bench.sv
`timescale 1ns/1ps
module vshift_unit_bench;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [31:0] operand_i = '0;
    logic [1:0]  width_i = '0;
    logic        left_i = 1'b0;
    logic        alt_i = 1'b0;
    logic        rotate_i = 1'b0;
    logic        carry_i = 1'b0;
    logic        amt_from_reg_i = 1'b0;
    logic [5:0]  amt_imm_i = '0;
    logic [31:0] amt_reg_i = '0;
    logic [31:0] result_o;
    logic        carry_o, neg_o, zero_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk_i = ~clk_i;

    vshift_unit u_vshift_unit (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .operand_i      (operand_i),
        .width_i        (width_i),
        .left_i         (left_i),
        .alt_i          (alt_i),
        .rotate_i       (rotate_i),
        .carry_i        (carry_i),
        .amt_from_reg_i (amt_from_reg_i),
        .amt_imm_i      (amt_imm_i),
        .amt_reg_i      (amt_reg_i),
        .result_o       (result_o),
        .carry_o        (carry_o),
        .neg_o          (neg_o),
        .zero_o         (zero_o)
    );

    // one bit position per step, straight from the requirements
    task automatic model(input logic [31:0] op, input logic [1:0] wc, input logic lf,
                         input logic alt, input logic rot, input logic ci, input int amt,
                         output logic [31:0] r, output logic c, output logic n, output logic z);
        int          w;
        logic [63:0] mask;
        logic [63:0] x;
        logic        hi, lo, cc;
        w    = (wc == 2'b00) ? 8 : (wc == 2'b01) ? 16 : 32;
        mask = (64'd1 << w) - 64'd1;
        x    = {32'd0, op} & mask;
        cc   = ci;
        for (int i = 0; i < amt; i++) begin
            hi = x[w-1];
            lo = x[0];
            if (!rot && !lf) begin
                x = x >> 1;
                if (alt && hi) x = x | (64'd1 << (w - 1));
                cc = lo;
            end else if (!rot && lf) begin
                x = ((x << 1) & mask) | {63'd0, alt & lo};
                cc = hi;
            end else if (rot && !lf) begin
                x = x >> 1;
                if (alt ? lo : cc) x = x | (64'd1 << (w - 1));
                cc = lo;
            end else begin
                x = ((x << 1) & mask) | {63'd0, (alt ? hi : cc)};
                cc = hi;
            end
        end
        r = (op & ~mask[31:0]) | x[31:0];
        c = cc;
        n = x[w-1];
        z = (x == 64'd0);
    endtask

    // drive at a falling edge, check one clock later
    task automatic apply(input logic [31:0] op, input logic [1:0] wc, input logic lf,
                         input logic alt, input logic rot, input logic ci, input logic sel,
                         input logic [5:0] imm, input logic [31:0] rg, input string tag);
        logic [31:0] er;
        logic        ec, en, ez;
        int          amt;
        amt = sel ? int'(rg[5:0]) : int'(imm);
        model(op, wc, lf, alt, rot, ci, amt, er, ec, en, ez);
        operand_i = op; width_i = wc; left_i = lf; alt_i = alt; rotate_i = rot;
        carry_i = ci; amt_from_reg_i = sel; amt_imm_i = imm; amt_reg_i = rg;
        @(negedge clk_i);
        tests++;
        if (result_o !== er || carry_o !== ec || neg_o !== en || zero_o !== ez) begin
            fails++;
            $display("FAIL %s: res=%h c=%b n=%b z=%b expected res=%h c=%b n=%b z=%b (op=%h w=%0d amt=%0d)",
                     tag, result_o, carry_o, neg_o, zero_o, er, ec, en, ez, op, wc, amt);
        end
    endtask

    function automatic string kind_tag(input logic lf, input logic alt, input logic rot);
        if (!rot && !lf) return alt ? "R3 sign right" : "R2 zero right";
        if (!rot)        return alt ? "R5 rep left" : "R4 zero left";
        return alt ? "R7 wrap rotate" : "R6 carry rotate";
    endfunction

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        tests++;
        if (result_o !== 32'd0 || carry_o !== 1'b0 || neg_o !== 1'b0 || zero_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: res=%h c=%b n=%b z=%b expected all zero",
                     result_o, carry_o, neg_o, zero_o);
        end
        rst_ni = 1'b1;
        @(negedge clk_i);

        // R2 logical right
        apply(32'h0000_00F1, 2'b10, 0, 0, 0, 0, 0, 6'd4,  '0, "R2 right 4");
        apply(32'hABCD_00F1, 2'b00, 0, 0, 0, 1, 0, 6'd8,  '0, "R2 right equal width");
        apply(32'hABCD_00F1, 2'b00, 0, 0, 0, 1, 0, 6'd9,  '0, "R2 right beyond width");
        // R3 arithmetic right
        apply(32'h0000_0080, 2'b00, 0, 1, 0, 0, 0, 6'd3,  '0, "R3 sign fill 3");
        apply(32'h1234_8001, 2'b01, 0, 1, 0, 0, 0, 6'd40, '0, "R3 sign beyond width");
        // R4 and R5 left shifts
        apply(32'h8000_0003, 2'b10, 1, 0, 0, 0, 0, 6'd1,  '0, "R4 left 1 carry out");
        apply(32'h0000_0081, 2'b00, 1, 1, 0, 0, 0, 6'd3,  '0, "R5 low bit replicate");
        apply(32'h0000_0001, 2'b10, 1, 1, 0, 0, 0, 6'd63, '0, "R5 replicate beyond");
        // R6 through-carry ring
        apply(32'h0000_0001, 2'b00, 0, 0, 1, 0, 0, 6'd1,  '0, "R6 ror carry 1");
        apply(32'h0000_005A, 2'b00, 1, 0, 1, 1, 0, 6'd9,  '0, "R6 full ring turn");
        apply(32'hF000_005A, 2'b00, 0, 0, 1, 1, 0, 6'd18, '0, "R6 two ring turns");
        apply(32'h8765_4321, 2'b10, 1, 0, 1, 0, 0, 6'd35, '0, "R6 32-bit ring wrap");
        // R7 in-lane wrap
        apply(32'h0000_0001, 2'b00, 0, 1, 1, 0, 0, 6'd1,  '0, "R7 wrap right 1");
        apply(32'h0000_00C3, 2'b00, 0, 1, 1, 0, 0, 6'd8,  '0, "R7 full lane turn");
        apply(32'h8765_4321, 2'b10, 1, 1, 1, 1, 0, 6'd35, '0, "R7 32-bit wrap mod");
        // R8 zero amount for each kind
        for (int k = 0; k < 8; k++)
            apply(32'hDEAD_BEEF, 2'b01, k[1], k[0], k[2], k[0], 0, 6'd0, '0, "R8 zero amount");
        // R9 width codes and upper bits
        apply(32'hFFFF_FF01, 2'b00, 1, 0, 0, 0, 0, 6'd4,  '0, "R9 8-bit upper hold");
        apply(32'h8000_8000, 2'b11, 0, 1, 0, 0, 0, 6'd4,  '0, "R9 code 11 is 32-bit");
        // R10 flags
        apply(32'h1111_0080, 2'b00, 1, 0, 0, 0, 0, 6'd1,  '0, "R10 zero flag lane");
        apply(32'h0000_4000, 2'b01, 1, 0, 0, 0, 0, 6'd1,  '0, "R10 negative flag");
        // R11 amount source
        apply(32'h0000_0F00, 2'b10, 0, 0, 0, 0, 1, 6'd60, 32'hFFFF_FFC3, "R11 register low bits");
        apply(32'h0000_0F00, 2'b10, 0, 0, 0, 0, 0, 6'd2,  32'hFFFF_FFFF, "R11 immediate chosen");

        // R1 back-to-back random sweep, every kind, width and source
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] op, rg;
            logic [2:0]  kb;
            logic [1:0]  wc;
            logic [5:0]  im;
            logic        ci, sl;
            op = $urandom; rg = $urandom; kb = 3'($urandom); wc = 2'($urandom);
            im = 6'($urandom); ci = 1'($urandom); sl = 1'($urandom);
            if (i % 5 == 0) op = op & 32'h0000_00FF;
            apply(op, wc, kb[1], kb[0], kb[2], ci, sl, im, rg, kind_tag(kb[1], kb[0], kb[2]));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule